// File: doc/BRIEF.md
# Shared-Memory Bus Slave Window with Mailbox and Reset Cells

This block decodes a 4 MB shared-memory window on a parallel backplane bus and forwards accesses to an external SRAM. The window base comes from hex switch inputs. In 32-bit address mode three switches take part in the match. In 24-bit address mode only the lowest switch does. Because the window must sit on a 4 MB boundary, the two low bits of the lowest switch are ignored. A local processor port shares the same SRAM. When both sides request in the same cycle, the host bus always wins.

Two words near the top of the first megabyte of the window are trigger cells. A host write to the mailbox word raises an interrupt flag toward the local processor. The flag stays set until the local side writes that word. A host write to the reset word starts a fixed-length software-reset pulse. Both cells are also ordinary RAM words, so they read back the last value written. Local firmware zeroes the mailbox after servicing it, and the host polls for zero before posting again, which makes the mailbox work as a semaphore.

Top module: `shwin_slave`

## Requirements
- R1: While rst_ni is low, and in the first cycle after it rises, bus_ack_o, loc_ack_o, mbox_irq_o, swrst_o and ram_en_o are all 0.
- R2: In 32-bit mode (mode32_i=1), a host request hits only when addr[31:28]==sw_hi_i, addr[27:24]==sw_mid_i and addr[23:22]==sw_lo_i[3:2]. sw_lo_i[1:0] has no effect. A request that misses produces no acknowledge and no SRAM access.
- R3: In 24-bit mode (mode32_i=0), only addr[23:22]==sw_lo_i[3:2] is compared. addr[31:24] and the other two switches are ignored.
- R4: Lane enables, where ram_be_o bit i covers data bits [8i+7:8i]:
  - size 0 (byte) enables lane addr[1:0];
  - size 1 (16-bit) enables 4'b0011 when addr[1]=0 and 4'b1100 when addr[1]=1;
  - sizes 2 and 3 (32-bit) enable 4'b1111.
  - ram_addr_o is the word offset addr[21:2], and write data passes to ram_wdata_o unshifted.
- R5: An access served in cycle N is acknowledged for one cycle in N+1, on bus_ack_o for the host and on loc_ack_o for the local port. In that acknowledge cycle a read returns the SRAM word.
- R6: A local request made in the same cycle as a host hit is not served: it gets no SRAM access and no loc_ack_o, and must be presented again.
- R7: A host write to window word offset 0xFFFE0 (any lanes) sets mbox_irq_o from the next cycle. The data is still written to RAM.
- R8: mbox_irq_o stays set until a granted local write to local offset 0xFFFE0 clears it, from the next cycle. Further host writes keep it set. A host mailbox write in the same cycle as a local clear leaves it set.
- R9: A host write to window word offset 0xFFFFC drives swrst_o high from the next cycle for 16 cycles, whatever the data. A new write while the pulse is running restarts the 16-cycle count.
- R10: Reads of either cell return the stored value and raise no event. A local write to the reset cell produces no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mode32_i | input | 1 | 1: 32-bit address decode, 0: 24-bit |
| sw_hi_i | input | 4 | Base switch for A31–A28 |
| sw_mid_i | input | 4 | Base switch for A27–A24 |
| sw_lo_i | input | 4 | Base switch for A23–A20 |
| bus_req_i | input | 1 | Host access strobe, one cycle |
| bus_we_i | input | 1 | Host write |
| bus_addr_i | input | 32 | Host byte address |
| bus_size_i | input | 2 | 0 byte, 1 16-bit, 2/3 32-bit |
| bus_wdata_i | input | 32 | Host write data, lane aligned |
| bus_ack_o | output | 1 | Host acknowledge |
| bus_rdata_o | output | 32 | Host read data, valid with acknowledge |
| loc_req_i | input | 1 | Local access strobe |
| loc_we_i | input | 1 | Local write |
| loc_addr_i | input | 22 | Local window byte offset |
| loc_size_i | input | 2 | Local access size, same encoding |
| loc_wdata_i | input | 32 | Local write data |
| loc_ack_o | output | 1 | Local acknowledge |
| loc_rdata_o | output | 32 | Local read data, valid with acknowledge |
| ram_en_o | output | 1 | SRAM access enable |
| ram_we_o | output | 1 | SRAM write |
| ram_be_o | output | 4 | SRAM byte lane enables |
| ram_addr_o | output | 20 | SRAM word address |
| ram_wdata_o | output | 32 | SRAM write data |
| ram_rdata_i | input | 32 | SRAM read data, one cycle after a read |
| mbox_irq_o | output | 1 | Mailbox interrupt toward the local processor |
| swrst_o | output | 1 | Software-reset pulse |

## Verification
The risky overlap is a host write to the mailbox word in the same cycle as the local firmware's clearing write to it. The bench provokes this with one stimulus cycle that drives both ports. It then judges three things: the local port gets no acknowledge, the flag stays set, and the retried clear succeeds on the next attempt. A second overlap is a repeat write to the reset word while the pulse is still running. Here the bench measures the pulse length from the last write. A cycle-by-cycle behavioural model also compares acknowledges, lanes, read data, the flag and the pulse on every clock.

// File: rtl/shwin_pkg.sv
package shwin_pkg;
  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_HALF = 2'd1;
  localparam logic [1:0] SZ_WORD = 2'd2;
endpackage

// File: rtl/shwin_decode.sv
module shwin_decode #(
  parameter int ADDR_W   = 32,
  parameter int WIN_BITS = 22
) (
  input  logic              mode32_i,
  input  logic [3:0]        sw_hi_i,
  input  logic [3:0]        sw_mid_i,
  input  logic [3:0]        sw_lo_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o
);
  localparam int LO_KEEP = 24 - WIN_BITS;   // switch bits above the window
  localparam int LO_DROP = 4 - LO_KEEP;     // switch bits forced by alignment

  logic lo_match;
  logic hi_match;

  generate
    if (LO_KEEP > 0) begin : g_lo
      assign lo_match = (addr_i[23:WIN_BITS] == sw_lo_i[3:LO_DROP]);
    end else begin : g_lo_none
      assign lo_match = 1'b1;
    end
    if (LO_DROP > 0) begin : g_drop
      logic unused_lo;
      assign unused_lo = ^sw_lo_i[LO_DROP-1:0];
    end
  endgenerate

  assign hi_match = (addr_i[31:28] == sw_hi_i) && (addr_i[27:24] == sw_mid_i);
  assign hit_o    = lo_match && (!mode32_i || hi_match);
endmodule

// File: rtl/shwin_lanes.sv
module shwin_lanes #(
  parameter int DATA_W = 32,
  localparam int NB     = DATA_W / 8,
  localparam int LANE_W = $clog2(NB)
) (
  input  logic [1:0]        size_i,
  input  logic [LANE_W-1:0] addr_lo_i,
  output logic [NB-1:0]     be_o
);
  import shwin_pkg::*;

  for (genvar i = 0; i < NB; i++) begin : g_lane
    localparam logic [LANE_W-1:0] IDX = LANE_W'(i);
    always_comb begin
      unique case (size_i)
        SZ_BYTE: be_o[i] = (addr_lo_i == IDX);
        SZ_HALF: be_o[i] = (addr_lo_i[LANE_W-1:1] == IDX[LANE_W-1:1]);
        default: be_o[i] = 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/shwin_events.sv
module shwin_events #(
  parameter int PULSE = 16,
  localparam int CNT_W = $clog2(PULSE + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic mbox_set_i,
  input  logic mbox_clr_i,
  input  logic rst_trig_i,
  output logic mbox_irq_o,
  output logic swrst_o
);
  logic             irq_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_q <= 1'b0;
    end else if (mbox_set_i) begin
      irq_q <= 1'b1;                      // set wins over clear
    end else if (mbox_clr_i) begin
      irq_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (rst_trig_i) begin
      cnt_q <= CNT_W'(PULSE);             // retrigger restarts the pulse
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign mbox_irq_o = irq_q;
  assign swrst_o    = (cnt_q != '0);
endmodule

// File: rtl/shwin_slave.sv
module shwin_slave #(
  parameter int                ADDR_W   = 32,
  parameter int                DATA_W   = 32,
  parameter int                WIN_BITS = 22,
  parameter logic [WIN_BITS-1:0] MBOX_OFS = 22'h0FFFE0,
  parameter logic [WIN_BITS-1:0] RST_OFS  = 22'h0FFFFC,
  parameter int                PULSE    = 16,
  localparam int               NB       = DATA_W / 8,
  localparam int               LANE_W   = $clog2(NB),
  localparam int               WORD_W   = WIN_BITS - LANE_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                mode32_i,
  input  logic [3:0]          sw_hi_i,
  input  logic [3:0]          sw_mid_i,
  input  logic [3:0]          sw_lo_i,
  input  logic                bus_req_i,
  input  logic                bus_we_i,
  input  logic [ADDR_W-1:0]   bus_addr_i,
  input  logic [1:0]          bus_size_i,
  input  logic [DATA_W-1:0]   bus_wdata_i,
  output logic                bus_ack_o,
  output logic [DATA_W-1:0]   bus_rdata_o,
  input  logic                loc_req_i,
  input  logic                loc_we_i,
  input  logic [WIN_BITS-1:0] loc_addr_i,
  input  logic [1:0]          loc_size_i,
  input  logic [DATA_W-1:0]   loc_wdata_i,
  output logic                loc_ack_o,
  output logic [DATA_W-1:0]   loc_rdata_o,
  output logic                ram_en_o,
  output logic                ram_we_o,
  output logic [NB-1:0]       ram_be_o,
  output logic [WORD_W-1:0]   ram_addr_o,
  output logic [DATA_W-1:0]   ram_wdata_o,
  input  logic [DATA_W-1:0]   ram_rdata_i,
  output logic                mbox_irq_o,
  output logic                swrst_o
);
  localparam logic [WORD_W-1:0] MBOX_WORD = MBOX_OFS[WIN_BITS-1:LANE_W];
  localparam logic [WORD_W-1:0] RST_WORD  = RST_OFS[WIN_BITS-1:LANE_W];

  logic              dec_hit;
  logic              host_hit;
  logic              loc_gnt;
  logic [WORD_W-1:0] host_word;
  logic [WORD_W-1:0] loc_word;
  logic [NB-1:0]     host_be;
  logic [NB-1:0]     loc_be;
  logic              host_mbox_wr;
  logic              loc_mbox_wr;
  logic              host_rst_wr;
  logic              bus_ack_q;
  logic              loc_ack_q;

  shwin_decode #(.ADDR_W(ADDR_W), .WIN_BITS(WIN_BITS)) u_decode (
    .mode32_i (mode32_i),
    .sw_hi_i  (sw_hi_i),
    .sw_mid_i (sw_mid_i),
    .sw_lo_i  (sw_lo_i),
    .addr_i   (bus_addr_i),
    .hit_o    (dec_hit)
  );

  shwin_lanes #(.DATA_W(DATA_W)) u_host_lanes (
    .size_i    (bus_size_i),
    .addr_lo_i (bus_addr_i[LANE_W-1:0]),
    .be_o      (host_be)
  );

  shwin_lanes #(.DATA_W(DATA_W)) u_loc_lanes (
    .size_i    (loc_size_i),
    .addr_lo_i (loc_addr_i[LANE_W-1:0]),
    .be_o      (loc_be)
  );

  assign host_hit  = bus_req_i && dec_hit;
  assign loc_gnt   = loc_req_i && !host_hit;   // host has fixed priority
  assign host_word = bus_addr_i[WIN_BITS-1:LANE_W];
  assign loc_word  = loc_addr_i[WIN_BITS-1:LANE_W];

  assign host_mbox_wr = host_hit && bus_we_i && (host_word == MBOX_WORD);
  assign host_rst_wr  = host_hit && bus_we_i && (host_word == RST_WORD);
  assign loc_mbox_wr  = loc_gnt  && loc_we_i && (loc_word == MBOX_WORD);

  always_comb begin
    ram_en_o    = host_hit || loc_gnt;
    ram_we_o    = host_hit ? bus_we_i    : (loc_gnt && loc_we_i);
    ram_be_o    = host_hit ? host_be     : (loc_gnt ? loc_be : '0);
    ram_addr_o  = host_hit ? host_word   : loc_word;
    ram_wdata_o = host_hit ? bus_wdata_i : loc_wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bus_ack_q <= 1'b0;
      loc_ack_q <= 1'b0;
    end else begin
      bus_ack_q <= host_hit;
      loc_ack_q <= loc_gnt;
    end
  end

  assign bus_ack_o   = bus_ack_q;
  assign loc_ack_o   = loc_ack_q;
  assign bus_rdata_o = bus_ack_q ? ram_rdata_i : '0;
  assign loc_rdata_o = loc_ack_q ? ram_rdata_i : '0;

  shwin_events #(.PULSE(PULSE)) u_events (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .mbox_set_i (host_mbox_wr),
    .mbox_clr_i (loc_mbox_wr),
    .rst_trig_i (host_rst_wr),
    .mbox_irq_o (mbox_irq_o),
    .swrst_o    (swrst_o)
  );
endmodule

// File: rtl/shwin_slave_chk.sv
module shwin_slave_chk #(
  parameter int PULSE = 16,
  parameter int NB    = 4
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          bus_req_i,
  input logic          loc_req_i,
  input logic          bus_ack_o,
  input logic          loc_ack_o,
  input logic          ram_en_o,
  input logic [NB-1:0] ram_be_o,
  input logic          mbox_irq_o,
  input logic          swrst_o,
  input logic          host_mbox_wr,
  input logic          loc_mbox_wr
);
  int run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) run_q <= 0;
    else         run_q <= swrst_o ? run_q + 1 : 0;
  end

  a_r5_ack_needs_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_ack_o |-> $past(bus_req_i));
  a_r6_loc_ack_needs_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    loc_ack_o |-> $past(loc_req_i));
  a_r6_single_owner: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(bus_ack_o && loc_ack_o));
  a_r4_lanes_present: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_en_o |-> (ram_be_o != '0));
  a_r2_idle_no_ram: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!bus_req_i && !loc_req_i) |-> !ram_en_o);
  a_r7_mbox_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_mbox_wr |=> mbox_irq_o);
  a_r8_mbox_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mbox_irq_o && !loc_mbox_wr) |=> mbox_irq_o);
  a_r8_mbox_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (loc_mbox_wr && !host_mbox_wr) |=> !mbox_irq_o);
  a_r9_pulse_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(swrst_o) |-> (run_q >= PULSE));
endmodule

bind shwin_slave shwin_slave_chk #(.PULSE(PULSE), .NB(NB)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .bus_req_i    (bus_req_i),
  .loc_req_i    (loc_req_i),
  .bus_ack_o    (bus_ack_o),
  .loc_ack_o    (loc_ack_o),
  .ram_en_o     (ram_en_o),
  .ram_be_o     (ram_be_o),
  .mbox_irq_o   (mbox_irq_o),
  .swrst_o      (swrst_o),
  .host_mbox_wr (host_mbox_wr),
  .loc_mbox_wr  (loc_mbox_wr)
);

// File: tb/shwin_slave_tb.sv
module shwin_slave_tb;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_ni = 1'b0;
  logic        mode32 = 1'b1;
  logic [3:0]  sw_hi = 4'h5, sw_mid = 4'h0, sw_lo = 4'hC;
  logic        h_req = 0, h_we = 0;
  logic [31:0] h_addr = 0, h_wdata = 0;
  logic [1:0]  h_size = 0;
  logic        l_req = 0, l_we = 0;
  logic [21:0] l_addr = 0;
  logic [31:0] l_wdata = 0;
  logic [1:0]  l_size = 0;

  logic        bus_ack, loc_ack, ram_en, ram_we, mbox_irq, swrst;
  logic [31:0] bus_rdata, loc_rdata, ram_wdata;
  logic [3:0]  ram_be;
  logic [19:0] ram_addr;
  logic [31:0] sram_q = 0;

  shwin_slave u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .mode32_i(mode32),
    .sw_hi_i(sw_hi), .sw_mid_i(sw_mid), .sw_lo_i(sw_lo),
    .bus_req_i(h_req), .bus_we_i(h_we), .bus_addr_i(h_addr),
    .bus_size_i(h_size), .bus_wdata_i(h_wdata),
    .bus_ack_o(bus_ack), .bus_rdata_o(bus_rdata),
    .loc_req_i(l_req), .loc_we_i(l_we), .loc_addr_i(l_addr),
    .loc_size_i(l_size), .loc_wdata_i(l_wdata),
    .loc_ack_o(loc_ack), .loc_rdata_o(loc_rdata),
    .ram_en_o(ram_en), .ram_we_o(ram_we), .ram_be_o(ram_be),
    .ram_addr_o(ram_addr), .ram_wdata_o(ram_wdata), .ram_rdata_i(sram_q),
    .mbox_irq_o(mbox_irq), .swrst_o(swrst)
  );

  int n_chk = 0;
  int n_fail = 0;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // external SRAM seen by the design
  logic [31:0] sram [int];
  always @(posedge clk) begin
    if (ram_en) begin
      if (ram_we) begin
        logic [31:0] w;
        w = sram.exists(int'(ram_addr)) ? sram[int'(ram_addr)] : 32'h0;
        for (int i = 0; i < 4; i++) if (ram_be[i]) w[8*i +: 8] = ram_wdata[8*i +: 8];
        sram[int'(ram_addr)] = w;
      end else begin
        sram_q <= sram.exists(int'(ram_addr)) ? sram[int'(ram_addr)] : 32'h0;
      end
    end
  end

  // ---------------- behavioural reference model ----------------
  logic [31:0] mm [int];
  bit  e_bus_ack, e_loc_ack, e_bus_rd, e_loc_rd, e_irq;
  logic [31:0] e_bus_rdata, e_loc_rdata;
  int  e_cnt;

  function automatic bit f_hit(logic [31:0] a);
    if (mode32) return a[31:28] == sw_hi && a[27:24] == sw_mid && a[23:22] == sw_lo[3:2];
    return a[23:22] == sw_lo[3:2];
  endfunction

  function automatic logic [3:0] f_be(logic [1:0] sz, logic [1:0] a);
    case (sz)
      2'd0: return 4'b0001 << a;
      2'd1: return a[1] ? 4'b1100 : 4'b0011;
      default: return 4'b1111;
    endcase
  endfunction

  function automatic logic [31:0] m_rd(int w);
    return mm.exists(w) ? mm[w] : 32'h0;
  endfunction

  task automatic m_wr(int w, logic [3:0] be, logic [31:0] d);
    logic [31:0] v;
    v = m_rd(w);
    for (int i = 0; i < 4; i++) if (be[i]) v[8*i +: 8] = d[8*i +: 8];
    mm[w] = v;
  endtask

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      e_bus_ack = 0; e_loc_ack = 0; e_bus_rd = 0; e_loc_rd = 0; e_irq = 0; e_cnt = 0;
    end else begin
      bit hh, lg, trig;
      int hw, lw;
      hh = h_req && f_hit(h_addr);
      lg = l_req && !hh;
      hw = int'(h_addr[21:2]);
      lw = int'(l_addr[21:2]);
      trig = 0;
      e_bus_ack = hh; e_loc_ack = lg;
      e_bus_rd = hh && !h_we; e_loc_rd = lg && !l_we;
      if (hh) begin
        if (!h_we) e_bus_rdata = m_rd(hw);
        else begin
          m_wr(hw, f_be(h_size, h_addr[1:0]), h_wdata);
          if (hw == 32'h3FFF8) e_irq = 1;
          if (hw == 32'h3FFFF) trig = 1;
        end
      end
      if (lg) begin
        if (!l_we) e_loc_rdata = m_rd(lw);
        else begin
          m_wr(lw, f_be(l_size, l_addr[1:0]), l_wdata);
          if (lw == 32'h3FFF8) e_irq = 0;
        end
      end
      if (trig) e_cnt = 16;
      else if (e_cnt > 0) e_cnt--;
    end
  end

  bit run_cmp = 0;
  always @(negedge clk) begin
    if (rst_ni && run_cmp) begin
      bit hh, lg;
      hh = h_req && f_hit(h_addr);
      lg = l_req && !hh;
      check("R5 bus_ack", 32'(bus_ack), 32'(e_bus_ack));
      check("R6 loc_ack", 32'(loc_ack), 32'(e_loc_ack));
      check("R7 mbox_irq", 32'(mbox_irq), 32'(e_irq));
      check("R9 swrst", 32'(swrst), 32'(e_cnt > 0));
      check("R2 ram_en", 32'(ram_en), 32'(hh || lg));
      if (e_bus_rd) check("R5 bus_rdata", bus_rdata, e_bus_rdata);
      if (e_loc_rd) check("R5 loc_rdata", loc_rdata, e_loc_rdata);
      if (hh) check("R4 host lanes", 32'(ram_be), 32'(f_be(h_size, h_addr[1:0])));
      else if (lg) check("R4 local lanes", 32'(ram_be), 32'(f_be(l_size, l_addr[1:0])));
      if (hh || lg) check("R4 word addr", 32'(ram_addr), hh ? 32'(h_addr[21:2]) : 32'(l_addr[21:2]));
    end
  end

  // ---------------- stimulus ----------------
  task automatic go(bit hq, bit hwe, logic [31:0] ha, logic [1:0] hs, logic [31:0] hd,
                    bit lq, bit lwe, logic [21:0] la, logic [1:0] ls, logic [31:0] ld);
    @(posedge clk); #1;
    h_req = hq; h_we = hwe; h_addr = ha; h_size = hs; h_wdata = hd;
    l_req = lq; l_we = lwe; l_addr = la; l_size = ls; l_wdata = ld;
    @(posedge clk); #1;
    h_req = 0; h_we = 0; l_req = 0; l_we = 0;
    @(negedge clk);
  endtask

  task automatic hwr(logic [31:0] a, logic [1:0] s, logic [31:0] d);
    go(1, 1, a, s, d, 0, 0, 0, 0, 0);
  endtask
  task automatic hrd(logic [31:0] a, logic [1:0] s);
    go(1, 0, a, s, 0, 0, 0, 0, 0, 0);
  endtask
  task automatic lwr(logic [21:0] a, logic [1:0] s, logic [31:0] d);
    go(0, 0, 0, 0, 0, 1, 1, a, s, d);
  endtask
  task automatic lrd(logic [21:0] a, logic [1:0] s);
    go(0, 0, 0, 0, 0, 1, 0, a, s, 0);
  endtask

  localparam logic [31:0] BASE = 32'h50C0_0000;

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 bus_ack", 32'(bus_ack), 0);
    check("R1 loc_ack", 32'(loc_ack), 0);
    check("R1 mbox_irq", 32'(mbox_irq), 0);
    check("R1 swrst", 32'(swrst), 0);
    check("R1 ram_en", 32'(ram_en), 0);
    rst_ni = 1'b1;
    @(negedge clk);
    check("R1 after release", 32'({bus_ack, loc_ack, mbox_irq, swrst}), 0);
    run_cmp = 1;

    // R5 / R4: word, byte and 16-bit writes with read back
    hwr(BASE + 32'h100, 2, 32'h1122_3344);
    hrd(BASE + 32'h100, 2);
    check("R5 word read", bus_rdata, 32'h1122_3344);
    hwr(BASE + 32'h101, 0, 32'h0000_AA00);
    hrd(BASE + 32'h100, 2);
    check("R4 byte lane 1", bus_rdata, 32'h1122_AA44);
    hwr(BASE + 32'h102, 1, 32'hBEEF_0000);
    hrd(BASE + 32'h100, 2);
    check("R4 upper half", bus_rdata, 32'hBEEF_AA44);

    // R2: mismatch and ignored low switch bits
    hwr(32'h60C0_0104, 2, 32'hDEAD_BEEF);
    check("R2 miss no ack", 32'(bus_ack), 0);
    hrd(BASE + 32'h104, 2);
    check("R2 miss wrote nothing", bus_rdata, 32'h0);
    sw_lo = 4'hD;
    hrd(BASE + 32'h100, 2);
    check("R2 low switch bits ignored", 32'(bus_ack), 1);
    sw_lo = 4'hC;

    // R3: 24-bit mode
    mode32 = 1'b0;
    hrd(32'hFFC0_0100, 2);
    check("R3 upper bits ignored", bus_rdata, 32'hBEEF_AA44);
    hrd(32'h0080_0100, 2);
    check("R3 lowest switch compared", 32'(bus_ack), 0);
    mode32 = 1'b1;

    // R7 / R10: mailbox post and read back
    hwr(BASE + 32'hF_FFE0, 2, 32'h5A5A_0001);
    check("R7 irq raised", 32'(mbox_irq), 1);
    hrd(BASE + 32'hF_FFE0, 2);
    check("R10 mailbox reads as RAM", bus_rdata, 32'h5A5A_0001);
    lrd(22'hF_FFE0, 2);
    check("R10 local mailbox read", loc_rdata, 32'h5A5A_0001);
    check("R8 irq held", 32'(mbox_irq), 1);

    // R8 / R6: clear collides with a new post
    go(1, 1, BASE + 32'hF_FFE0, 2, 32'h5A5A_0002, 1, 1, 22'hF_FFE0, 2, 32'h0);
    check("R6 local not acked", 32'(loc_ack), 0);
    check("R8 post wins over clear", 32'(mbox_irq), 1);
    lwr(22'hF_FFE0, 2, 32'h0);
    check("R8 local clear", 32'(mbox_irq), 0);
    hrd(BASE + 32'hF_FFE0, 2);
    check("R10 semaphore zero", bus_rdata, 32'h0);
    hwr(BASE + 32'hF_FFE3, 0, 32'h7F00_0000);
    check("R7 byte post", 32'(mbox_irq), 1);
    lwr(22'hF_FFE0, 2, 32'h0);
    check("R8 second clear", 32'(mbox_irq), 0);

    // R9: software-reset pulse and retrigger
    hwr(BASE + 32'hF_FFFC, 2, 32'h0);
    n = 0;
    while (swrst && n < 100) begin n++; @(negedge clk); end
    check("R9 pulse length", 32'(n), 32'd16);
    hwr(BASE + 32'hF_FFFC, 0, 32'h0000_00FF);
    repeat (4) @(negedge clk);
    hwr(BASE + 32'hF_FFFE, 1, 32'h1234_0000);
    n = 0;
    while (swrst && n < 100) begin n++; @(negedge clk); end
    check("R9 retrigger restarts", 32'(n), 32'd16);

    // R10: no events from reads or local writes to the reset cell
    lwr(22'hF_FFFC, 2, 32'hFFFF_FFFF);
    check("R10 local reset-cell write", 32'(swrst), 0);
    hrd(BASE + 32'hF_FFFC, 2);
    check("R10 reset cell reads as RAM", bus_rdata, 32'hFFFF_FFFF);
    check("R10 read no pulse", 32'(swrst), 0);

    // local port plain traffic
    lwr(22'h200, 1, 32'h0000_CAFE);
    lrd(22'h200, 2);
    check("R5 local read", loc_rdata, 32'h0000_CAFE);
    hrd(BASE + 32'h200, 0);
    check("R5 shared with host", bus_rdata, 32'h0000_CAFE);

    repeat (3) @(negedge clk);
    summary();
  end
endmodule